// File: doc/BRIEF.md
# Modem Adapter Register Interface

This block is the host-side register file of a low-speed modem card sitting on an 8-bit I/O bus. Four consecutive port addresses, starting at a parameterised base (0x80 by default), give the host a received-data port, a status port, a line-format port, a control port and a timer-restart port. Bus accesses are strobe based, and each read or write strobe acts exactly once however long it is held.

On the line side, the block hands transmit bytes to a separate serial framer over a valid/ready pair and accepts received bytes from it the same way. It takes three error pulses from the framer, a carrier-detect level and an active-low ring level. It drives the off-hook output and a DTR output. DTR is not a register bit. It follows hook and originate writes, ring arrival and carrier loss. A 50 ms timer, prescaled from the clock frequency parameter, is armed by the host and reports expiry in the status byte.

Top module: `modem_regif`

## Requirements
- R1: While reset is asserted, `dtr`, `off_hook`, `tx_valid` and `bus_rdata` are 0, `ctrl_reg` is 0x00, `line_cfg` is 0x16 (8 data bits, parity inhibited) and `rx_ready` is 1. After release, a status read returns 0x80 as long as the framer is not idle.
- R2: Only addresses whose bits [7:2] equal those of `BASE_ADDR` respond, with bits [1:0] selecting the port (0 data, 1 status/line format, 2 control, 3 timer). Accesses elsewhere change no state and leave `bus_rdata` unchanged.
- R3: A byte offered with `rx_valid` is accepted only while `rx_ready` is high and sets receive-full (status bit 0), which drops `rx_ready`. Reading port 0 returns that byte and clears receive-full.
- R4: Writing port 0 stores the transmit byte, clears transmit-empty (status bit 1) and makes it pending. `tx_valid` is raised for a pending byte only while control bit 1 is set, and a `tx_valid`/`tx_ready` handshake retires it. Transmit-empty is set again once nothing is pending and `tx_idle` is high.
- R5: Error pulses set parity (bit 2), framing (bit 3) and overrun (bit 4). A status read returns them and then clears all three, and accepting a new received byte clears them as well.
- R6: Writing port 1 loads `line_cfg` and writing port 2 loads `ctrl_reg`; bit 7 of the control register drives `off_hook`. Reads of ports 2 and 3 return 0x00.
- R7: A control write that clears the off-hook bit (7) while it was set drops DTR. A control write that leaves both originate (bit 2) and off-hook set raises DTR only if one of those two bits changed.
- R8: Status bit 6 shows carrier and bit 7 shows the ring level (1 = not ringing). The sampled ring going active raises DTR, and the sampled carrier going inactive drops DTR. A drop wins over a raise in the same cycle.
- R9: Any write to port 3 clears the timer flag (status bit 5) and restarts the timer. The flag sets exactly CLK_HZ/1000 × TIMEOUT_MS cycles after the arming write. Without an arming write the flag never sets.
- R10: A read or write strobe held high for several cycles has its side effect once, on its first cycle, and `bus_rdata` changes only on a decoded read strobe's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Bus port address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the strobe's first cycle |
| tx_data | output | 8 | Transmit byte to the framer |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Framer takes the transmit byte |
| tx_idle | input | 1 | Framer has nothing in flight |
| rx_data | input | 8 | Received byte from the framer |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive holding register empty |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_overrun | input | 1 | Overrun pulse |
| carrier_in | input | 1 | Carrier detect, active high |
| ring_n_in | input | 1 | Ring indicator, active low |
| line_cfg | output | 8 | Line format register to the framer |
| ctrl_reg | output | 8 | Control register |
| off_hook | output | 1 | Off-hook drive |
| dtr | output | 1 | Data terminal ready |

## Verification
The assertions check several rules on every cycle. The transmit offer is gated by the enable bit and held until it is taken. Receive-full drops after each accepted byte. DTR is low whenever off-hook falls and after carrier is lost. Read data stays put between read strobes. Exact register values have to come from the bench scenarios: the status byte after error pulses, loads and reads, the address decode, the DTR response to sequences of control writes, and the exact cycle on which the timer flag sets or stays clear.

// File: rtl/modem_regif_pkg.sv
package modem_regif_pkg;
  localparam int PORT_DATA = 0;
  localparam int PORT_STAT = 1;
  localparam int PORT_CTRL = 2;
  localparam int PORT_TIMR = 3;
  localparam int NPORTS    = 4;

  // status byte bit positions
  localparam int ST_RXFULL  = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_ERR_LO  = 2;
  localparam int ST_TIMER   = 5;
  localparam int ST_CARRIER = 6;
  localparam int ST_RING_N  = 7;

  // control byte bit positions
  localparam int CT_TXEN = 1;
  localparam int CT_ORIG = 2;
  localparam int CT_HOOK = 7;

  localparam logic [7:0] LINE_CFG_RST = 8'h16;
endpackage

// File: rtl/modem_busdec.sv
module modem_busdec #(
  parameter logic [7:0] BASE_ADDR = 8'h80,
  parameter int         NPORTS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [NPORTS-1:0] rd_stb,
  output logic [NPORTS-1:0] wr_stb
);
  localparam int SELW = $clog2(NPORTS);

  logic rd_q, wr_q;
  logic sel, rd_first, wr_first;

  assign sel      = (bus_addr[7:SELW] == BASE_ADDR[7:SELW]);
  assign rd_first = bus_rd & ~rd_q & sel;
  assign wr_first = bus_wr & ~wr_q & sel;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign rd_stb[p] = rd_first & (bus_addr[SELW-1:0] == SELW'(p));
    assign wr_stb[p] = wr_first & (bus_addr[SELW-1:0] == SELW'(p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= bus_rd;
      wr_q <= bus_wr;
    end
  end
endmodule

// File: rtl/modem_datapath.sv
module modem_datapath (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_rx,
  input  logic       rd_stat,
  input  logic       wr_tx,
  input  logic [7:0] wdata,
  input  logic       tx_en,
  input  logic       tx_ready,
  input  logic       tx_idle,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [2:0] err_in,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       tx_empty,
  output logic [2:0] err_flags
);
  logic       full_d, empty_d, pend_q, pend_d;
  logic [7:0] rxb_d, txb_d;
  logic [2:0] err_d;
  logic       rx_take, tx_fire;

  assign rx_ready = ~rx_full;
  assign rx_take  = rx_valid & ~rx_full;
  assign tx_valid = pend_q & tx_en;
  assign tx_fire  = tx_valid & tx_ready;

  always_comb begin
    full_d = rx_full;
    if (rd_rx)   full_d = 1'b0;
    if (rx_take) full_d = 1'b1;
    rxb_d = rx_take ? rx_data : rx_byte;

    err_d = err_flags;
    if (rd_stat || rx_take) err_d = '0;
    err_d = err_d | err_in;

    pend_d = pend_q;
    if (tx_fire) pend_d = 1'b0;
    if (wr_tx)   pend_d = 1'b1;
    txb_d = wr_tx ? wdata : tx_data;

    empty_d = tx_empty;
    if (wr_tx)                   empty_d = 1'b0;
    else if (!pend_q && tx_idle) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full   <= 1'b0;
      rx_byte   <= '0;
      err_flags <= '0;
      pend_q    <= 1'b0;
      tx_data   <= '0;
      tx_empty  <= 1'b0;
    end else begin
      rx_full   <= full_d;
      rx_byte   <= rxb_d;
      err_flags <= err_d;
      pend_q    <= pend_d;
      tx_data   <= txb_d;
      tx_empty  <= empty_d;
    end
  end
endmodule

// File: rtl/modem_linectl.sv
module modem_linectl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic old_hook,
  input  logic old_orig,
  input  logic new_hook,
  input  logic new_orig,
  input  logic carrier_in,
  input  logic ring_n_in,
  output logic cd_q,
  output logic ring_n_q,
  output logic dtr
);
  logic dtr_d, ring_edge, cd_loss, hook_drop, orig_raise;

  assign ring_edge  = ring_n_q & ~ring_n_in;
  assign cd_loss    = cd_q & ~carrier_in;
  assign hook_drop  = wr_ctrl & old_hook & ~new_hook;
  assign orig_raise = wr_ctrl & new_hook & new_orig &
                      ((old_hook ^ new_hook) | (old_orig ^ new_orig));

  always_comb begin
    dtr_d = dtr;
    if (ring_edge || orig_raise) dtr_d = 1'b1;
    if (hook_drop || cd_loss)    dtr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q     <= 1'b0;
      ring_n_q <= 1'b1;
      dtr      <= 1'b0;
    end else begin
      cd_q     <= carrier_in;
      ring_n_q <= ring_n_in;
      dtr      <= dtr_d;
    end
  end
endmodule

// File: rtl/modem_timer.sv
module modem_timer #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TIMEOUT_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic flag
);
  localparam int TICKS = CLK_HZ / 1000;
  localparam int TW    = $clog2(TICKS + 1);
  localparam int MW    = $clog2(TIMEOUT_MS + 1);

  logic          armed_q, armed_d, flag_d;
  logic [TW-1:0] tick_q, tick_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          tick_end;

  assign tick_end = (tick_q == TW'(TICKS - 1));

  always_comb begin
    armed_d = armed_q;
    tick_d  = tick_q;
    ms_d    = ms_q;
    flag_d  = flag;
    if (arm) begin
      armed_d = 1'b1;
      tick_d  = '0;
      ms_d    = '0;
      flag_d  = 1'b0;
    end else if (armed_q) begin
      if (tick_end) begin
        tick_d = '0;
        if (ms_q == MW'(TIMEOUT_MS - 1)) begin
          armed_d = 1'b0;
          flag_d  = 1'b1;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tick_q  <= '0;
      ms_q    <= '0;
      flag    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      tick_q  <= tick_d;
      ms_q    <= ms_d;
      flag    <= flag_d;
    end
  end
endmodule

// File: rtl/modem_regif.sv
module modem_regif
  import modem_regif_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR  = 8'h80,
  parameter int         CLK_HZ     = 125_000_000,
  parameter int         TIMEOUT_MS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic       tx_idle,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic       err_parity,
  input  logic       err_frame,
  input  logic       err_overrun,
  input  logic       carrier_in,
  input  logic       ring_n_in,
  output logic [7:0] line_cfg,
  output logic [7:0] ctrl_reg,
  output logic       off_hook,
  output logic       dtr
);
  logic [NPORTS-1:0] rd_stb, wr_stb;
  logic [7:0] rx_byte, status, rdata_d, line_d, ctrl_d;
  logic       rx_full, tx_empty, tmr_flag, cd_q, ring_n_q, rd_any;
  logic [2:0] err_flags;

  modem_busdec #(.BASE_ADDR(BASE_ADDR), .NPORTS(NPORTS)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .rd_stb(rd_stb), .wr_stb(wr_stb));

  modem_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .rd_rx(rd_stb[PORT_DATA]),
    .rd_stat(rd_stb[PORT_STAT]), .wr_tx(wr_stb[PORT_DATA]),
    .wdata(bus_wdata), .tx_en(ctrl_reg[CT_TXEN]), .tx_ready(tx_ready),
    .tx_idle(tx_idle), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .err_in({err_overrun, err_frame, err_parity}), .rx_byte(rx_byte),
    .rx_full(rx_full), .tx_empty(tx_empty), .err_flags(err_flags));

  modem_linectl u_line (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_stb[PORT_CTRL]),
    .old_hook(ctrl_reg[CT_HOOK]), .old_orig(ctrl_reg[CT_ORIG]),
    .new_hook(bus_wdata[CT_HOOK]), .new_orig(bus_wdata[CT_ORIG]),
    .carrier_in(carrier_in), .ring_n_in(ring_n_in),
    .cd_q(cd_q), .ring_n_q(ring_n_q), .dtr(dtr));

  modem_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(wr_stb[PORT_TIMR]), .flag(tmr_flag));

  assign status   = {ring_n_q, cd_q, tmr_flag, err_flags, tx_empty, rx_full};
  assign off_hook = ctrl_reg[CT_HOOK];
  assign rd_any   = |rd_stb;

  always_comb begin
    rdata_d = bus_rdata;
    if (rd_stb[PORT_DATA])                     rdata_d = rx_byte;
    if (rd_stb[PORT_STAT])                     rdata_d = status;
    if (rd_stb[PORT_CTRL] || rd_stb[PORT_TIMR]) rdata_d = 8'h00;
    line_d = wr_stb[PORT_STAT] ? bus_wdata : line_cfg;
    ctrl_d = wr_stb[PORT_CTRL] ? bus_wdata : ctrl_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      line_cfg  <= LINE_CFG_RST;
      ctrl_reg  <= '0;
    end else begin
      bus_rdata <= rdata_d;
      line_cfg  <= line_d;
      ctrl_reg  <= ctrl_d;
    end
  end
endmodule

// File: rtl/modem_regif_chk.sv
module modem_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_en,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       off_hook,
  input logic       dtr,
  input logic       cd_q,
  input logic       carrier_in,
  input logic       rd_any,
  input logic [7:0] bus_rdata
);
  p_tx_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_en);

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid || !tx_en));

  p_rx_full_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  p_onhook_drops_dtr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_hook) |-> !dtr);

  p_cd_loss_drops_dtr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q && !carrier_in) |=> !dtr);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(bus_rdata));
endmodule

bind modem_regif modem_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_en(ctrl_reg[1]), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .off_hook(off_hook), .dtr(dtr), .cd_q(cd_q), .carrier_in(carrier_in),
  .rd_any(rd_any), .bus_rdata(bus_rdata));

// File: tb/modem_regif_tb.sv
module modem_regif_tb_top;
  localparam int CLK_HZ = 100_000;
  localparam int TMO_MS = 50;
  localparam int TMO_CYC = (CLK_HZ / 1000) * TMO_MS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, rx_data = 8'h00;
  logic       bus_rd = 1'b0, bus_wr = 1'b0, tx_ready = 1'b0, tx_idle = 1'b0;
  logic       rx_valid = 1'b0, err_parity = 1'b0, err_frame = 1'b0, err_overrun = 1'b0;
  logic       carrier_in = 1'b0, ring_n_in = 1'b1;
  logic [7:0] bus_rdata, tx_data, line_cfg, ctrl_reg;
  logic       tx_valid, rx_ready, off_hook, dtr;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       sample_ev;

  always #4 clk = ~clk;

  modem_regif #(.BASE_ADDR(8'h80), .CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_idle(tx_idle), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .carrier_in(carrier_in), .ring_n_in(ring_n_in),
    .line_cfg(line_cfg), .ctrl_reg(ctrl_reg), .off_hook(off_hook), .dtr(dtr));

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t); ->sample_ev;
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d);
    rx_data = d; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check({7'd0, dtr}, 8'h00, "R1 dtr");
    check({7'd0, off_hook}, 8'h00, "R1 off_hook");
    check({7'd0, tx_valid}, 8'h00, "R1 tx_valid");
    check({7'd0, rx_ready}, 8'h01, "R1 rx_ready");
    check(line_cfg, 8'h16, "R1 line_cfg");
    check(ctrl_reg, 8'h00, "R1 ctrl_reg");
    check(bus_rdata, 8'h00, "R1 rdata");
    rst_n = 1'b1;
    repeat (6000) @(negedge clk);
    bus_read(8'h81, 8'h80, "R1 R9 status after reset, timer unarmed");

    // R9 timer: arming write lands on edge 0, flag sets on edge TMO_CYC
    tx_idle = 1'b1;
    @(negedge clk);
    bus_write(8'h83, 8'h5C);
    repeat (TMO_CYC - 3) @(negedge clk);
    bus_read(8'h81, 8'h82, "R9 flag clear one cycle early");
    bus_read(8'h81, 8'hA2, "R9 flag set at expiry");
    bus_write(8'h83, 8'h00);
    bus_read(8'h81, 8'h82, "R9 flag cleared by restart");

    // R3 receive path
    rx_send(8'hA5);
    check({7'd0, rx_ready}, 8'h00, "R3 rx_ready low when full");
    bus_read(8'h81, 8'h83, "R3 status receive full");
    bus_read(8'h80, 8'hA5, "R3 receive byte");
    bus_read(8'h81, 8'h82, "R3 full cleared by data read");

    // R10 held read strobe acts once
    rx_send(8'h3C);
    bus_addr = 8'h80; bus_rd = 1'b1;
    @(negedge clk);
    exp_q.push_back(8'h3C); tag_q.push_back("R10 first read"); ->sample_ev;
    rx_send(8'h77);
    @(negedge clk);
    check(bus_rdata, 8'h3C, "R10 rdata held during strobe");
    bus_rd = 1'b0;
    @(negedge clk);
    bus_read(8'h81, 8'h83, "R10 second byte still full");
    bus_read(8'h80, 8'h77, "R10 second byte");

    // R5 error flags
    err_parity = 1'b1; err_overrun = 1'b1;
    @(negedge clk);
    err_parity = 1'b0; err_overrun = 1'b0;
    bus_read(8'h81, 8'h96, "R5 parity and overrun");
    bus_read(8'h81, 8'h82, "R5 cleared by status read");
    err_frame = 1'b1;
    @(negedge clk);
    err_frame = 1'b0;
    rx_send(8'h11);
    bus_read(8'h81, 8'h83, "R5 framing cleared by new byte");
    bus_read(8'h80, 8'h11, "R5 byte after error");

    // R4 transmit path
    tx_idle = 1'b0;
    @(negedge clk);
    bus_write(8'h80, 8'h5A);
    check({7'd0, tx_valid}, 8'h00, "R4 no offer while disabled");
    bus_read(8'h81, 8'h80, "R4 transmit-empty cleared");
    bus_write(8'h82, 8'h02);
    check({7'd0, tx_valid}, 8'h01, "R4 offer once enabled");
    check(tx_data, 8'h5A, "R4 tx_data");
    check(ctrl_reg, 8'h02, "R6 ctrl_reg");
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check({7'd0, tx_valid}, 8'h00, "R4 offer retired");
    bus_read(8'h81, 8'h80, "R4 empty waits for idle");
    tx_idle = 1'b1;
    @(negedge clk);
    bus_read(8'h81, 8'h82, "R4 empty after idle");

    // R2 address decode
    bus_write(8'h84, 8'h99);
    check({7'd0, tx_valid}, 8'h00, "R2 write outside window ignored");
    bus_write(8'h7E, 8'h80);
    check({7'd0, off_hook}, 8'h00, "R2 control alias ignored");
    bus_read(8'h81, 8'h82, "R2 status still empty");
    bus_addr = 8'h90; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    check(bus_rdata, 8'h82, "R2 read outside window keeps rdata");

    // R6 line format and zero reads
    bus_write(8'h81, 8'h0B);
    check(line_cfg, 8'h0B, "R6 line_cfg");
    bus_read(8'h82, 8'h00, "R6 control port reads zero");
    bus_read(8'h83, 8'h00, "R6 timer port reads zero");

    // R7 DTR from control writes
    bus_write(8'h82, 8'h80);
    check({7'd0, off_hook}, 8'h01, "R6 off_hook");
    check({7'd0, dtr}, 8'h00, "R7 answer mode no dtr");
    bus_write(8'h82, 8'h84);
    check({7'd0, dtr}, 8'h01, "R7 originate raises dtr");
    bus_write(8'h82, 8'h04);
    check({7'd0, dtr}, 8'h00, "R7 on hook drops dtr");
    bus_write(8'h82, 8'h84);
    check({7'd0, dtr}, 8'h01, "R7 raise again");

    // R8 carrier and ring
    carrier_in = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(8'h81, 8'hC2, "R8 carrier in status");
    carrier_in = 1'b0;
    repeat (2) @(negedge clk);
    check({7'd0, dtr}, 8'h00, "R8 carrier loss drops dtr");
    bus_write(8'h82, 8'h86);
    check({7'd0, dtr}, 8'h00, "R7 unchanged hook and mode no raise");
    ring_n_in = 1'b0;
    repeat (2) @(negedge clk);
    check({7'd0, dtr}, 8'h01, "R8 ring raises dtr");
    bus_read(8'h81, 8'h02, "R8 ring in status");
    ring_n_in = 1'b1;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule